// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer with Byte-Wide Bus Port

This block runs the digital side of a 10-bit successive-approximation analog-to-digital converter and presents it to an 8-bit processor bus. A host starts a conversion by pulsing an active-low write strobe while chip select is low. The block holds its search in reset for as long as both strobes stay low. It latches the start when write returns high, waits for its internal phase counter to come round, and then resolves one bit per fixed step from the most significant bit down. It drives the trial code to an external DAC and comparator. It reads back the single comparator decision at the end of each step.

When the last bit is decided, the code is copied into a result register and an active-low interrupt is raised. The host reads the result as two bytes, high byte first. The first byte holds result bits 9..2. The second byte holds bits 1..0 in its top two positions and zeros below them. Any read or write falling edge made while chip select is low clears the interrupt. The data lines are enabled only while chip select and read are both low. If the interrupt output is wired back to the write input with chip select held low, the block converts continuously.

Top module: `sarConvCtrl`

## Requirements
- R1: After reset the interrupt output is high, the data output enable is low with the data output at zero, and the trial code is zero.
- R2: For an ideal comparator that reports "above" (cmpAbove=1) whenever the input code is greater than or equal to the trial code, the completed result equals the input code, including codes 0 and 1023.
- R3: The first read after an interrupt returns result[9:2]. The second read returns {result[1:0], 6'b000000}. A third read wraps back to the high byte.
- R4: dataOe is 1 exactly while csN and rdN are both low. While dataOe is 0, dataOut is zero.
- R5: While csN and wrN are both low, no conversion runs and the trial code stays zero, however long the pulse lasts. The conversion begins only after wrN rises.
- R6: The interrupt goes low between 84 and 96 clock cycles after the rising edge of wrN that starts a conversion.
- R7: The interrupt returns high after a falling edge of rdN or wrN made with csN low. Read or write strobes made with csN high leave it low.
- R8: A new start during a conversion abandons that conversion. Reads made before the new conversion completes return the previous result, and the restarted conversion then delivers its own result.
- R9: When the comparator never reports "above", the result is all zeros.
- R10: With intrN fed back to wrN and csN held low, conversions follow one another without further host action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select |
| wrN | input | 1 | Active-low write strobe; low with csN holds reset, rising edge starts |
| rdN | input | 1 | Active-low read strobe |
| cmpAbove | input | 1 | Comparator decision: input is at or above the trial code |
| trialCode | output | 10 | Code presented to the external DAC |
| intrN | output | 1 | Active-low end-of-conversion interrupt |
| dataOut | output | 8 | Result byte toward the pad tri-state buffer |
| dataOe | output | 1 | Output enable for the data pad buffer |

## Verification
A wrong bit index or step count shows up as a wrong byte on the very next read after the interrupt. It also moves the interrupt outside its 84 to 96 cycle window, so a timing slip is caught within one conversion. A byte pointer that fails to reset or to advance swaps the high and low bytes on the first or second read. A result register that is overwritten on abort returns the wrong byte during the restarted conversion, tens of cycles before its interrupt. Interrupt-clearing faults appear as intrN holding or dropping at the wrong strobe a few cycles after the synchronizer delay.

// File: rtl/sarPkg.sv
package sarPkg;
  // Strobes from the sequencer to the datapath, one cycle each
  typedef struct packed {
    logic clear;    // zero the trial code
    logic setBit;   // raise the trial bit under test
    logic decide;   // keep or drop the trial bit under test
    logic load;     // copy the finished trial code into the result
    logic ptrHigh;  // point the reader at the high byte
    logic ptrStep;  // advance the byte pointer after a read
  } strobes_t;
endpackage

// File: rtl/sarSync.sv
module sarSync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] pipe [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) pipe[0] <= '1;
          else       pipe[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) pipe[s] <= '1;
          else       pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/sarCtrl.sv
module sarCtrl
  import sarPkg::*;
#(
  parameter int BITS      = 10,
  parameter int STEP_CLKS = 8,
  parameter int PHASES    = 8,
  localparam int IDXW     = $clog2(BITS),
  localparam int STEPW    = $clog2(STEP_CLKS),
  localparam int PHW      = $clog2(PHASES)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            csS,
  input  logic            wrS,
  input  logic            rdS,
  output strobes_t        strb,
  output logic [IDXW-1:0] bitIdx,
  output logic            intrN
);
  typedef enum logic [2:0] {ST_IDLE, ST_HOLD, ST_ALIGN, ST_CONV, ST_DONE} state_t;

  localparam logic [PHW-1:0]   PH_LAST   = PHW'(PHASES - 1);
  localparam logic [STEPW-1:0] STEP_LAST = STEPW'(STEP_CLKS - 1);
  localparam logic [IDXW-1:0]  IDX_TOP   = IDXW'(BITS - 1);

  state_t           state, stateNx;
  logic [PHW-1:0]   phaseCnt;
  logic [STEPW-1:0] stepCnt;
  logic             wrQ, rdQ;
  logic             hold, wrFall, rdFall, rdRise;

  assign hold   = !csS && !wrS;
  assign wrFall = wrQ && !wrS && !csS;
  assign rdFall = rdQ && !rdS && !csS;
  assign rdRise = !rdQ && rdS && !csS;

  always_comb begin
    stateNx      = state;
    strb         = '0;
    strb.ptrStep = rdRise;
    if (hold) begin
      stateNx    = ST_HOLD;
      strb.clear = 1'b1;
    end else begin
      unique case (state)
        ST_HOLD: begin
          stateNx      = ST_ALIGN;
          strb.clear   = 1'b1;
          strb.ptrHigh = 1'b1;
        end
        ST_ALIGN: if (phaseCnt == PH_LAST) stateNx = ST_CONV;
        ST_CONV: begin
          if (stepCnt == '0) strb.setBit = 1'b1;
          if (stepCnt == STEP_LAST) begin
            strb.decide = 1'b1;
            if (bitIdx == '0) stateNx = ST_DONE;
          end
        end
        ST_DONE: begin
          strb.load    = 1'b1;
          strb.ptrHigh = 1'b1;
          stateNx      = ST_IDLE;
        end
        default: stateNx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      stepCnt  <= '0;
      bitIdx   <= IDX_TOP;
      wrQ      <= 1'b1;
      rdQ      <= 1'b1;
      intrN    <= 1'b1;
    end else begin
      state    <= stateNx;
      phaseCnt <= phaseCnt + 1'b1;
      wrQ      <= wrS;
      rdQ      <= rdS;
      if (state == ST_CONV && !hold) begin
        if (stepCnt == STEP_LAST) begin
          stepCnt <= '0;
          bitIdx  <= bitIdx - 1'b1;
        end else begin
          stepCnt <= stepCnt + 1'b1;
        end
      end else begin
        stepCnt <= '0;
        bitIdx  <= IDX_TOP;
      end
      if (strb.load)             intrN <= 1'b0;
      else if (wrFall || rdFall) intrN <= 1'b1;
    end
  end

  // R2
  bit_walk_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.decide && bitIdx != '0) |=> bitIdx == IDXW'($past(bitIdx) - 1'b1));

  // R8
  full_search_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> ($past(strb.decide) && $past(bitIdx) == '0));

  // R6
  intr_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> !intrN);
endmodule

// File: rtl/sarData.sv
module sarData
  import sarPkg::*;
#(
  parameter int BITS      = 10,
  parameter int BUSW      = 8,
  localparam int IDXW     = $clog2(BITS),
  localparam int LOW_BITS = BITS - BUSW
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobes_t        strb,
  input  logic [IDXW-1:0] bitIdx,
  input  logic            cmpAbove,
  output logic [BITS-1:0] trial,
  output logic [BUSW-1:0] dataByte
);
  logic [BITS-1:0] result;
  logic            ptrLow;
  logic [BUSW-1:0] hiByte, loByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         trial <= '0;
    else if (strb.clear)               trial <= '0;
    else if (strb.setBit)              trial[bitIdx] <= 1'b1;
    else if (strb.decide && !cmpAbove) trial[bitIdx] <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          result <= '0;
    else if (strb.load) result <= trial;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             ptrLow <= 1'b0;
    else if (strb.ptrHigh) ptrLow <= 1'b0;
    else if (strb.ptrStep) ptrLow <= !ptrLow;
  end

  assign hiByte   = result[BITS-1 -: BUSW];
  assign loByte   = {result[LOW_BITS-1:0], {(BUSW-LOW_BITS){1'b0}}};
  assign dataByte = ptrLow ? loByte : hiByte;

  // R5
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> trial == '0);

  // R3
  ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ptrStep && !strb.ptrHigh) |=> ptrLow != $past(ptrLow));
endmodule

// File: rtl/sarConvCtrl.sv
module sarConvCtrl #(
  parameter int BITS      = 10,
  parameter int BUSW      = 8,
  parameter int STEP_CLKS = 8,
  parameter int PHASES    = 8,
  parameter int SYNC      = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            csN,
  input  logic            wrN,
  input  logic            rdN,
  input  logic            cmpAbove,
  output logic [BITS-1:0] trialCode,
  output logic            intrN,
  output logic [BUSW-1:0] dataOut,
  output logic            dataOe
);
  localparam int IDXW = $clog2(BITS);

  sarPkg::strobes_t strb;
  logic [IDXW-1:0]  bitIdx;
  logic [2:0]       pinSync;
  logic [BUSW-1:0]  dataByte;

  sarSync #(.WIDTH(3), .STAGES(SYNC)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({csN, wrN, rdN}),
    .dout(pinSync)
  );

  sarCtrl #(.BITS(BITS), .STEP_CLKS(STEP_CLKS), .PHASES(PHASES)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .csS   (pinSync[2]),
    .wrS   (pinSync[1]),
    .rdS   (pinSync[0]),
    .strb  (strb),
    .bitIdx(bitIdx),
    .intrN (intrN)
  );

  sarData #(.BITS(BITS), .BUSW(BUSW)) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .bitIdx  (bitIdx),
    .cmpAbove(cmpAbove),
    .trial   (trialCode),
    .dataByte(dataByte)
  );

  assign dataOe  = !csN && !rdN;
  assign dataOut = dataOe ? dataByte : '0;

  // R4
  bus_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csN || rdN) |-> (dataOut == '0));
endmodule

// File: tb/sarConvCtrl_tb.sv
module sarConvCtrl_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1, wrDrv = 1'b1, rdN = 1'b1;
  logic       freeRun = 1'b0, negMode = 1'b0;
  logic [9:0] vin = '0;
  logic [9:0] trialCode;
  logic       intrN, dataOe, cmpAbove, wrN;
  logic [7:0] dataOut;

  int errors = 0, checks = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];
  logic [7:0] capByte;
  event       rdEv;

  always #2 clk = ~clk;

  assign cmpAbove = !negMode && (vin >= trialCode);
  assign wrN      = wrDrv & (freeRun ? intrN : 1'b1);

  sarConvCtrl u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .rdN(rdN),
    .cmpAbove(cmpAbove), .trialCode(trialCode), .intrN(intrN),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pushResult(input logic [9:0] code);
    expQ.push_back(code[9:2]);        tagQ.push_back("R2/R3 high byte");
    expQ.push_back({code[1:0], 6'b0}); tagQ.push_back("R2/R3 low byte");
  endtask

  task automatic startConv(input logic [9:0] code);
    vin = code;
    csN = 1'b0; wrDrv = 1'b0;
    repeat (4) @(negedge clk);
    wrDrv = 1'b1;
  endtask

  task automatic waitIntr(output int n);
    n = 0;
    while (intrN && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic readByte();
    csN = 1'b0; rdN = 1'b0;
    repeat (3) @(negedge clk);
    check(dataOe == 1'b1, "R4 enable during read", dataOe, 1);
    capByte = dataOut;
    ->rdEv;
    rdN = 1'b1;
    @(negedge clk);
    csN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Monitor: pops one expected byte per completed read
  initial forever begin
    @(rdEv);
    if (expQ.size() == 0) check(1'b0, "scoreboard underflow", capByte, 0);
    else begin
      automatic logic [7:0] e = expQ.pop_front();
      automatic string t = tagQ.pop_front();
      check(capByte == e, t, capByte, e);
    end
  end

  task automatic fullConv(input logic [9:0] code, input logic [9:0] expect10);
    int n;
    startConv(code);
    waitIntr(n);
    // R6 window from the write rising edge
    check(n >= 84 && n <= 96, "R6 interrupt latency", n, 90);
    pushResult(expect10);
    readByte();
    // R7 read strobe clears interrupt
    check(intrN == 1'b1, "R7 read clears interrupt", intrN, 1);
    readByte();
  endtask

  initial begin
    repeat (200000) @(negedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    int falls;
    logic prevIntr;
    repeat (5) @(negedge clk);
    // R1 reset state
    check(intrN == 1'b1, "R1 intr idle", intrN, 1);
    check(dataOe == 1'b0, "R1 enable idle", dataOe, 0);
    check(dataOut == 8'h00, "R1 data idle", dataOut, 0);
    check(trialCode == 10'd0, "R1 trial idle", trialCode, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R4 enable needs both strobes low
    csN = 1'b0; @(negedge clk);
    check(dataOe == 1'b0 && dataOut == 0, "R4 cs only", dataOe, 0);
    csN = 1'b1; rdN = 1'b0; @(negedge clk);
    check(dataOe == 1'b0 && dataOut == 0, "R4 rd only", dataOe, 0);
    rdN = 1'b1; repeat (4) @(negedge clk);

    // R2 assorted codes including both ends
    fullConv(10'h2A5, 10'h2A5);
    fullConv(10'd0, 10'd0);
    fullConv(10'd1023, 10'd1023);
    fullConv(10'd512, 10'd512);
    fullConv(10'd1, 10'd1);

    // R3 third read wraps to the high byte
    expQ.push_back(8'h00); tagQ.push_back("R3 wrap to high");
    readByte();

    // R7 strobes with chip select high leave interrupt set
    startConv(10'h155);
    waitIntr(n);
    csN = 1'b1; rdN = 1'b0;
    repeat (3) @(negedge clk);
    check(dataOe == 1'b0, "R4 enable with cs high", dataOe, 0);
    rdN = 1'b1; wrDrv = 1'b0;
    repeat (3) @(negedge clk);
    wrDrv = 1'b1;
    repeat (4) @(negedge clk);
    check(intrN == 1'b0, "R7 no clear with cs high", intrN, 0);
    pushResult(10'h155);
    readByte();
    readByte();
    // R7 write falling edge clears interrupt
    startConv(10'h0F0);
    waitIntr(n);
    csN = 1'b0; wrDrv = 1'b0;
    repeat (4) @(negedge clk);
    check(intrN == 1'b1, "R7 write clears interrupt", intrN, 1);
    wrDrv = 1'b1;
    waitIntr(n);
    pushResult(10'h0F0);
    readByte();
    readByte();

    // R5 long hold keeps the search in reset
    vin = 10'd777;
    csN = 1'b0; wrDrv = 1'b0;
    repeat (300) @(negedge clk);
    check(intrN == 1'b1, "R5 no completion during hold", intrN, 1);
    check(trialCode == 10'd0, "R5 trial zero during hold", trialCode, 0);
    wrDrv = 1'b1;
    waitIntr(n);
    check(n >= 84 && n <= 96, "R5 start on write rise", n, 90);
    pushResult(10'd777);
    readByte();
    readByte();

    // R8 restart mid-conversion keeps old result until completion
    startConv(10'd800);
    repeat (40) @(negedge clk);
    expQ.push_back(8'd777 >> 2); tagQ.push_back("R8 old result during conversion");
    expQ[expQ.size()-1] = 10'd777 >> 2;
    readByte();
    startConv(10'd555);
    waitIntr(n);
    check(n >= 84 && n <= 96, "R8 restarted latency", n, 90);
    expQ.push_back(10'd555 >> 2);           tagQ.push_back("R8 new high byte");
    expQ.push_back({2'(10'd555 & 3), 6'b0}); tagQ.push_back("R8 new low byte");
    readByte();
    readByte();

    // R9 comparator never above
    negMode = 1'b1;
    fullConv(10'd900, 10'd0);
    negMode = 1'b0;

    // R10 free-running loop
    vin = 10'd333;
    csN = 1'b0; freeRun = 1'b1; wrDrv = 1'b0;
    repeat (4) @(negedge clk);
    wrDrv = 1'b1;
    falls = 0; prevIntr = intrN;
    for (int i = 0; i < 420; i++) begin
      @(negedge clk);
      if (prevIntr && !intrN) falls++;
      prevIntr = intrN;
    end
    check(falls >= 3, "R10 back-to-back conversions", falls, 4);
    freeRun = 1'b0; csN = 1'b1;
    repeat (4) @(negedge clk);
    waitIntr(n);
    pushResult(10'd333);
    readByte();
    readByte();

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "scoreboard drained", expQ.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule